// File: doc/BRIEF.md
# Miss Tracking Entry File

This block keeps the small set of outstanding-miss entries that lets an L1 data cache keep accepting accesses while line fills are pending. Each access that the cache pipeline finds missing in its tag array is presented on the lookup port. The block compares the access's line address against every live entry, decides whether the access can be answered as a hit or must wait, and, where no entry covers the line, claims a free one. Each entry keeps the line address, a modified bit, a data-arrived bit, a "request recorded" bit and the tag of the latest waiting access.

Toward the next cache level, only one fill request can be outstanding. When no request is outstanding, a scan picks the lowest-numbered entry that is live, still has no data and holds a recorded access, and issues its line address. Responses name the entry. A non-final beat marks the entry's data as arrived. The final beat frees the entry, reports its modified bit and recorded tag on the release port, and lets the next request go out.

Top module: `miss_track_file`

## Requirements
- R1: The line address of an access is its address with the low log2(LINE_BYTES) bits cleared. Two accesses that differ only in those bits use the same entry, and `req_addr` always carries a line address.
- R2: A lookup that matches no live entry claims the lowest-numbered free entry, and `res_entry` gives that index with `res_tracked`=1. A load is answered as a miss (`res_hit`=0). A store is answered as a hit and starts with its modified bit set.
- R3: A lookup that matches no live entry when no entry is free is answered with `res_hit`=0 and `res_tracked`=0. Nothing is claimed and no entry changes.
- R4: A store that matches a live entry is answered as a hit. It sets that entry's modified bit and records its tag.
- R5: A load that matches an entry whose data has arrived is answered as a hit and leaves the recorded tag unchanged.
- R6: A load that matches an entry with no data yet is answered as a miss, and its tag becomes the entry's recorded tag.
- R7: At most one fill request is outstanding. After `req_valid` pulses, no further request is issued until a final response beat (`rf_valid`=1, `rf_last`=1) has been taken.
- R8: With no request outstanding, the request goes to the lowest-numbered entry that is live, has no data arrived and holds a recorded access. It carries that entry's index and its recorded tag as it stood before this cycle's lookup.
- R9: A final beat on a live entry frees it. One cycle later `rls_valid` pulses with that index, the entry's modified bit and its recorded tag.
- R10: A non-final beat (`rf_valid`=1, `rf_last`=0) on a live entry marks its data as arrived. That entry is then no longer a request candidate.
- R11: A response and a lookup in the same cycle both take effect, with the response applied first. A lookup in the cycle an entry is freed sees that entry as free and may claim it.
- R12: `full` is 1 exactly when every entry is live. After reset `full` is 0 and every pulse output is 0.
- R13: A response naming an entry that is not live changes nothing and produces no release.

Lookup results (`res_*`), requests and releases are all registered: they appear in the cycle after the inputs that caused them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup presented this cycle |
| lk_addr | input | ADDR_W | Byte address of the access |
| lk_store | input | 1 | 1 for a store, 0 for a load |
| lk_tag | input | TAG_W | Identifier of the access |
| res_valid | output | 1 | Lookup answer valid |
| res_hit | output | 1 | Access treated as a hit |
| res_tracked | output | 1 | An entry covers the access |
| res_entry | output | IDX_W | Index of that entry |
| req_valid | output | 1 | Fill request pulse to next level |
| req_addr | output | ADDR_W | Line address requested |
| req_entry | output | IDX_W | Entry index carried with the request |
| req_tag | output | TAG_W | Recorded tag of the entry |
| rf_valid | input | 1 | Response beat from next level |
| rf_entry | input | IDX_W | Entry the beat belongs to |
| rf_last | input | 1 | Final beat, frees the entry |
| rls_valid | output | 1 | Entry freed pulse |
| rls_entry | output | IDX_W | Freed entry index |
| rls_modified | output | 1 | Modified bit of the freed entry |
| rls_tag | output | TAG_W | Recorded tag of the freed entry |
| full | output | 1 | All entries live |

## Verification
Any corrupted entry field surfaces at the ports within a few cycles. A wrong live bit or line address changes the next lookup's index or hit answer. A wrong data-arrived or recorded bit changes which entry the scan requests, or whether a request goes out at all. A lost modified bit or tag shows up as a wrong value on the release pulse one cycle after the final beat. A busy interlock that fails shows up as two requests with no final beat between them, and one that sticks shows up as no request at all. A reference model stepped every cycle therefore compares the answer, request, release and full outputs on every clock. It covers a directed sequence through every classification, the full and same-cycle-release corners, and a long randomized stretch over a few shared lines.

// File: rtl/mtf_pkg.sv
package mtf_pkg;

    // What a lookup does to the file this cycle
    typedef enum logic [2:0] {
        LK_IDLE,
        LK_REJECT,          // no match, no room
        LK_NEW,             // claim a free entry
        LK_MERGE_ST,        // store onto live entry
        LK_MERGE_LD_HIT,    // load onto entry whose data is in
        LK_MERGE_LD_WAIT    // load onto entry still waiting
    } lk_kind_e;

    function automatic lk_kind_e classify(input logic vld, input logic matched,
                                          input logic room, input logic store,
                                          input logic arrived);
        if (!vld) return LK_IDLE;
        if (!matched) return room ? LK_NEW : LK_REJECT;
        if (store) return LK_MERGE_ST;
        return arrived ? LK_MERGE_LD_HIT : LK_MERGE_LD_WAIT;
    endfunction

endpackage

// File: rtl/mtf_pick.sv
// Lowest-index-first priority encoder
module mtf_pick #(
    parameter int W  = 8,
    parameter int IW = (W > 1) ? $clog2(W) : 1
) (
    input  logic [W-1:0]  cand,
    output logic          found,
    output logic [IW-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (cand[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/mtf_match.sv
// Parallel line-address compare against every entry
module mtf_match #(
    parameter int N     = 8,
    parameter int BLK_W = 27
) (
    input  logic [N-1:0]            live,
    input  logic [N-1:0][BLK_W-1:0] blk,
    input  logic [BLK_W-1:0]        probe,
    output logic [N-1:0]            hit
);
    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign hit[g] = live[g] && (blk[g] == probe);
    end
endmodule

// File: rtl/miss_track_file.sv
module miss_track_file
    import mtf_pkg::*;
#(
    parameter int N_ENTRY    = 8,
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 32,
    parameter int TAG_W      = 6,
    parameter int IDX_W      = (N_ENTRY > 1) ? $clog2(N_ENTRY) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_valid,
    input  logic [ADDR_W-1:0] lk_addr,
    input  logic              lk_store,
    input  logic [TAG_W-1:0]  lk_tag,
    output logic              res_valid,
    output logic              res_hit,
    output logic              res_tracked,
    output logic [IDX_W-1:0]  res_entry,
    output logic              req_valid,
    output logic [ADDR_W-1:0] req_addr,
    output logic [IDX_W-1:0]  req_entry,
    output logic [TAG_W-1:0]  req_tag,
    input  logic              rf_valid,
    input  logic [IDX_W-1:0]  rf_entry,
    input  logic              rf_last,
    output logic              rls_valid,
    output logic [IDX_W-1:0]  rls_entry,
    output logic              rls_modified,
    output logic [TAG_W-1:0]  rls_tag,
    output logic              full
);
    localparam int OFS_W = (LINE_BYTES > 1) ? $clog2(LINE_BYTES) : 1;
    localparam int BLK_W = ADDR_W - OFS_W;

    typedef struct packed {
        logic [N_ENTRY-1:0]              live;
        logic [N_ENTRY-1:0]              dirty;
        logic [N_ENTRY-1:0]              filled;
        logic [N_ENTRY-1:0]              waiting;
        logic [N_ENTRY-1:0][BLK_W-1:0]   blk;
        logic [N_ENTRY-1:0][TAG_W-1:0]   tag;
        logic                            busy;
        logic                            res_valid;
        logic                            res_hit;
        logic                            res_tracked;
        logic [IDX_W-1:0]                res_entry;
        logic                            req_valid;
        logic [ADDR_W-1:0]               req_addr;
        logic [IDX_W-1:0]                req_entry;
        logic [TAG_W-1:0]                req_tag;
        logic                            rls_valid;
        logic [IDX_W-1:0]                rls_entry;
        logic                            rls_modified;
        logic [TAG_W-1:0]                rls_tag;
    } st_t;

    st_t st_q, st_d;

    // ---- response decode: applied ahead of the lookup ----
    logic [N_ENTRY-1:0] drop_mask, beat_mask;
    logic [N_ENTRY-1:0] live_eff, filled_eff;
    logic               drop_fire;
    logic               drop_dirty;
    logic [TAG_W-1:0]   drop_tag;

    for (genvar g = 0; g < N_ENTRY; g++) begin : g_rsp
        assign drop_mask[g] = rf_valid && rf_last  && (rf_entry == IDX_W'(g)) && st_q.live[g];
        assign beat_mask[g] = rf_valid && !rf_last && (rf_entry == IDX_W'(g)) && st_q.live[g];
    end

    assign live_eff   = st_q.live & ~drop_mask;
    assign filled_eff = (st_q.filled | beat_mask) & live_eff;
    assign drop_fire  = |drop_mask;

    always_comb begin
        drop_dirty = 1'b0;
        drop_tag   = '0;
        for (int i = 0; i < N_ENTRY; i++) begin
            if (drop_mask[i]) begin
                drop_dirty = st_q.dirty[i];
                drop_tag   = st_q.tag[i];
            end
        end
    end

    // ---- line match, free slot, request scan ----
    logic [BLK_W-1:0]   lk_blk;
    logic [N_ENTRY-1:0] match_vec;
    logic               match_found, free_found, scan_found;
    logic [IDX_W-1:0]   match_idx, free_idx, scan_idx;

    assign lk_blk = lk_addr[ADDR_W-1:OFS_W];

    mtf_match #(.N(N_ENTRY), .BLK_W(BLK_W)) u_match (
        .live (live_eff),
        .blk  (st_q.blk),
        .probe(lk_blk),
        .hit  (match_vec)
    );

    mtf_pick #(.W(N_ENTRY), .IW(IDX_W)) u_pick_match (
        .cand (match_vec),
        .found(match_found),
        .idx  (match_idx)
    );

    mtf_pick #(.W(N_ENTRY), .IW(IDX_W)) u_pick_free (
        .cand (~live_eff),
        .found(free_found),
        .idx  (free_idx)
    );

    mtf_pick #(.W(N_ENTRY), .IW(IDX_W)) u_pick_scan (
        .cand (live_eff & ~filled_eff & st_q.waiting),
        .found(scan_found),
        .idx  (scan_idx)
    );

    lk_kind_e kind;
    assign kind = classify(lk_valid, match_found, free_found, lk_store,
                           filled_eff[match_idx]);

    // ---- next state ----
    always_comb begin
        st_d = st_q;
        st_d.res_valid    = 1'b0;
        st_d.res_hit      = 1'b0;
        st_d.res_tracked  = 1'b0;
        st_d.res_entry    = '0;
        st_d.req_valid    = 1'b0;
        st_d.req_addr     = '0;
        st_d.req_entry    = '0;
        st_d.req_tag      = '0;
        st_d.rls_valid    = 1'b0;
        st_d.rls_entry    = '0;
        st_d.rls_modified = 1'b0;
        st_d.rls_tag      = '0;

        // response first
        st_d.live   = live_eff;
        st_d.filled = filled_eff;
        st_d.dirty  = st_q.dirty & live_eff;
        st_d.waiting = st_q.waiting & live_eff;
        if (drop_fire) begin
            st_d.rls_valid    = 1'b1;
            st_d.rls_entry    = rf_entry;
            st_d.rls_modified = drop_dirty;
            st_d.rls_tag      = drop_tag;
            st_d.busy         = 1'b0;
        end

        // one outstanding request, lowest eligible entry
        if (!st_q.busy && scan_found) begin
            st_d.req_valid = 1'b1;
            st_d.req_addr  = {st_q.blk[scan_idx], {OFS_W{1'b0}}};
            st_d.req_entry = scan_idx;
            st_d.req_tag   = st_q.tag[scan_idx];
            st_d.busy      = 1'b1;
        end

        // lookup
        if (kind != LK_IDLE) st_d.res_valid = 1'b1;
        unique case (kind)
            LK_NEW: begin
                st_d.live[free_idx]    = 1'b1;
                st_d.blk[free_idx]     = lk_blk;
                st_d.dirty[free_idx]   = lk_store;
                st_d.filled[free_idx]  = 1'b0;
                st_d.waiting[free_idx] = 1'b1;
                st_d.tag[free_idx]     = lk_tag;
                st_d.res_hit     = lk_store;
                st_d.res_tracked = 1'b1;
                st_d.res_entry   = free_idx;
            end
            LK_MERGE_ST: begin
                st_d.dirty[match_idx]   = 1'b1;
                st_d.waiting[match_idx] = 1'b1;
                st_d.tag[match_idx]     = lk_tag;
                st_d.res_hit     = 1'b1;
                st_d.res_tracked = 1'b1;
                st_d.res_entry   = match_idx;
            end
            LK_MERGE_LD_HIT: begin
                st_d.res_hit     = 1'b1;
                st_d.res_tracked = 1'b1;
                st_d.res_entry   = match_idx;
            end
            LK_MERGE_LD_WAIT: begin
                st_d.waiting[match_idx] = 1'b1;
                st_d.tag[match_idx]     = lk_tag;
                st_d.res_tracked = 1'b1;
                st_d.res_entry   = match_idx;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign res_valid    = st_q.res_valid;
    assign res_hit      = st_q.res_hit;
    assign res_tracked  = st_q.res_tracked;
    assign res_entry    = st_q.res_entry;
    assign req_valid    = st_q.req_valid;
    assign req_addr     = st_q.req_addr;
    assign req_entry    = st_q.req_entry;
    assign req_tag      = st_q.req_tag;
    assign rls_valid    = st_q.rls_valid;
    assign rls_entry    = st_q.rls_entry;
    assign rls_modified = st_q.rls_modified;
    assign rls_tag      = st_q.rls_tag;
    assign full         = &st_q.live;

    // ---- assertions ----
    a_r1_unique_match: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match_vec));

    a_r7_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> !req_valid);

    a_r3_untracked_is_miss: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_tracked) |-> !res_hit);

    a_r9_release_cause: assert property (@(posedge clk) disable iff (!rst_n)
        rls_valid |-> $past(rf_valid && rf_last));

    a_r12_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !(rf_valid && rf_last)) |=> full);

    a_r13_no_release_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_valid && rf_last && !drop_fire) |=> !rls_valid);

endmodule

// File: tb/tb_miss_track_file.sv
`timescale 1ns/1ps
module tb_miss_track_file;
    localparam int N = 8;
    localparam int AW = 32;
    localparam int TW = 6;
    localparam int IW = 3;
    localparam int OW = 5;   // 32-byte lines

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic          lk_valid = 0, lk_store = 0;
    logic [AW-1:0] lk_addr = '0;
    logic [TW-1:0] lk_tag = '0;
    logic          rf_valid = 0, rf_last = 0;
    logic [IW-1:0] rf_entry = '0;
    logic          res_valid, res_hit, res_tracked, req_valid, rls_valid, rls_modified, full;
    logic [IW-1:0] res_entry, req_entry, rls_entry;
    logic [AW-1:0] req_addr;
    logic [TW-1:0] req_tag, rls_tag;

    miss_track_file dut (
        .clk(clk), .rst_n(rst_n),
        .lk_valid(lk_valid), .lk_addr(lk_addr), .lk_store(lk_store), .lk_tag(lk_tag),
        .res_valid(res_valid), .res_hit(res_hit), .res_tracked(res_tracked), .res_entry(res_entry),
        .req_valid(req_valid), .req_addr(req_addr), .req_entry(req_entry), .req_tag(req_tag),
        .rf_valid(rf_valid), .rf_entry(rf_entry), .rf_last(rf_last),
        .rls_valid(rls_valid), .rls_entry(rls_entry), .rls_modified(rls_modified), .rls_tag(rls_tag),
        .full(full)
    );

    int compared = 0;
    int mismatched = 0;

    // ---- reference model ----
    bit             mv[N], mmod[N], marr[N], mhas[N];
    logic [AW-1:0]  mline[N];
    logic [TW-1:0]  mtag[N];
    bit             mbusy;
    logic [AW-1:0]  e_res, e_req, e_rls;  // packed expectations
    bit             e_req_v;
    int             e_req_e;

    task automatic model_reset();
        for (int i = 0; i < N; i++) begin
            mv[i] = 0; mmod[i] = 0; marr[i] = 0; mhas[i] = 0; mline[i] = '0; mtag[i] = '0;
        end
        mbusy = 0; e_res = '0; e_req = '0; e_rls = '0; e_req_v = 0; e_req_e = 0;
    endtask

    // expected packing: res = {valid,hit,tracked,entry}; req = {valid,entry,tag} plus addr separate
    logic [AW-1:0] e_req_addr;

    task automatic model_step(bit lv, logic [AW-1:0] la, bit ls, logic [TW-1:0] lt,
                              bit fv, int fe, bit fl);
        bit busy_pre;
        logic [AW-1:0] line;
        int hit_i, free_i;
        busy_pre = mbusy;
        e_res = '0; e_req = '0; e_rls = '0; e_req_v = 0; e_req_addr = '0;
        if (fv && mv[fe]) begin
            if (fl) begin
                e_rls = {20'd0, 1'b1, 3'(fe), mmod[fe], mtag[fe]};
                mv[fe] = 0; mmod[fe] = 0; marr[fe] = 0; mhas[fe] = 0;
                mbusy = 0;
            end else marr[fe] = 1;
        end
        if (!busy_pre) begin
            for (int i = 0; i < N; i++) begin
                if (mv[i] && !marr[i] && mhas[i]) begin
                    e_req = {22'd0, 1'b1, 3'(i), mtag[i]};
                    e_req_addr = mline[i];
                    e_req_v = 1; e_req_e = i;
                    mbusy = 1;
                    break;
                end
            end
        end
        if (lv) begin
            line = {la[AW-1:OW], 5'd0};
            hit_i = -1; free_i = -1;
            for (int i = 0; i < N; i++) if (mv[i] && mline[i] == line) hit_i = i;
            for (int i = N - 1; i >= 0; i--) if (!mv[i]) free_i = i;
            if (hit_i < 0 && free_i < 0) e_res = {26'd0, 3'b100, 3'd0};
            else if (hit_i < 0) begin
                mv[free_i] = 1; mline[free_i] = line; mmod[free_i] = ls;
                marr[free_i] = 0; mhas[free_i] = 1; mtag[free_i] = lt;
                e_res = {26'd0, 1'b1, ls, 1'b1, 3'(free_i)};
            end else if (ls) begin
                mmod[hit_i] = 1; mhas[hit_i] = 1; mtag[hit_i] = lt;
                e_res = {26'd0, 3'b111, 3'(hit_i)};
            end else if (marr[hit_i]) begin
                e_res = {26'd0, 3'b111, 3'(hit_i)};
            end else begin
                mhas[hit_i] = 1; mtag[hit_i] = lt;
                e_res = {26'd0, 3'b101, 3'(hit_i)};
            end
        end
    endtask

    function automatic bit model_full();
        bit f = 1;
        for (int i = 0; i < N; i++) f &= mv[i];
        return f;
    endfunction

    function automatic bit model_any();
        bit a = 0;
        for (int i = 0; i < N; i++) a |= mv[i];
        return a;
    endfunction

    task automatic cmp(string req, string what, logic [AW-1:0] act, logic [AW-1:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        cmp("R2 R3 R4 R5 R6", "res", {26'd0, res_valid, res_hit, res_tracked, res_entry}, e_res);
        cmp("R7 R8", "req", {22'd0, req_valid, req_entry, req_tag}, e_req);
        cmp("R1 R8", "req_addr", req_valid ? req_addr : '0, e_req_addr);
        cmp("R9", "rls", {20'd0, rls_valid, rls_entry, rls_modified, rls_tag}, e_rls);
        cmp("R12", "full", {31'd0, full}, {31'd0, model_full()});
    endtask

    // one clock: drive at falling edge, model on rising, compare at next falling
    task automatic cyc(bit lv, logic [AW-1:0] la, bit ls, logic [TW-1:0] lt,
                       bit fv, int fe, bit fl);
        lk_valid = lv; lk_addr = la; lk_store = ls; lk_tag = lt;
        rf_valid = fv; rf_entry = IW'(fe); rf_last = fl;
        @(posedge clk);
        model_step(lv, la, ls, lt, fv, fe, fl);
        @(negedge clk);
        compare_all();
    endtask

    task automatic idle(); cyc(0, '0, 0, '0, 0, 0, 0); endtask
    task automatic ld(logic [AW-1:0] a, logic [TW-1:0] t); cyc(1, a, 0, t, 0, 0, 0); endtask
    task automatic st(logic [AW-1:0] a, logic [TW-1:0] t); cyc(1, a, 1, t, 0, 0, 0); endtask

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        compare_all();   // R12: reset state
        rst_n = 1'b1;

        ld(32'h1000_0004, 6'd1);                          // R2 load alloc
        cmp("R2", "load alloc entry/hit/tracked", {res_entry, res_hit, res_tracked}, {3'd0, 1'b0, 1'b1});
        ld(32'h1000_001c, 6'd2);                          // R1 R6 same line
        cmp("R6", "merge load miss", {res_entry, res_hit, res_tracked}, {3'd0, 1'b0, 1'b1});
        cmp("R1", "line address", req_addr, 32'h1000_0000);
        cmp("R8", "first request tag", {req_valid, req_tag}, {1'b1, 6'd1});
        st(32'h2000_0008, 6'd3);                          // R2 store alloc
        cmp("R2", "store alloc hit", {res_entry, res_hit}, {3'd1, 1'b1});
        cmp("R7", "no second request", {31'd0, req_valid}, 32'd0);
        st(32'h1000_0010, 6'd4);                          // R4
        cmp("R4", "store merge hit", {res_entry, res_hit}, {3'd0, 1'b1});
        cyc(0, '0, 0, '0, 1, 0, 0);                       // R10 beat
        ld(32'h1000_0000, 6'd5);                          // R5
        cmp("R5", "load after arrival hit", {31'd0, res_hit}, 32'd1);
        cyc(0, '0, 0, '0, 1, 0, 1);                       // R9 release
        cmp("R9", "release dirty/tag", {rls_valid, rls_entry, rls_modified, rls_tag}, {1'b1, 3'd0, 1'b1, 6'd4});
        idle();                                           // R8 next request
        cmp("R8", "next request entry", {req_valid, req_entry, req_tag}, {1'b1, 3'd1, 6'd3});
        cyc(0, '0, 0, '0, 1, 0, 1);                       // R13 stale entry
        cmp("R13", "no release on free entry", {31'd0, rls_valid}, 32'd0);

        for (int i = 0; i < 7; i++) ld(32'h3000_0000 + 32'(i) * 32'h20, TW'(10 + i));
        cmp("R12", "full after fill", {31'd0, full}, 32'd1);
        ld(32'h4000_0000, 6'd20);                         // R3
        cmp("R3", "reject when full", {res_valid, res_hit, res_tracked}, 3'b100);
        st(32'h3000_0004, 6'd21);
        cmp("R4", "merge while full", {res_hit, res_tracked, res_entry}, {2'b11, 3'd0});
        cyc(1, 32'h5000_0000, 0, 6'd22, 1, 1, 1);         // R11
        cmp("R11", "claim freed slot", {res_tracked, res_entry, rls_valid, rls_entry}, {1'b1, 3'd1, 1'b1, 3'd1});
        cmp("R11", "full after swap", {31'd0, full}, 32'd1);
        idle();
        cmp("R8", "lowest candidate", {req_valid, req_entry}, {1'b1, 3'd0});

        // randomized stretch with a responder
        begin
            bit pend = 1; int pend_e = 0; int dly = 2;
            void'($urandom(32'd7));
            for (int c = 0; c < 3000; c++) begin
                bit lv = ($urandom % 3) != 0;
                logic [AW-1:0] a = 32'h6000_0000 + 32'($urandom % 12) * 32'h20 + 32'($urandom % 32);
                bit fv = 0, fl = 0; int fe = 0;
                if (pend) begin
                    if (dly == 0) begin
                        fv = 1; fe = pend_e; fl = ($urandom % 2) == 0;
                        if (fl) pend = 0; else dly = $urandom % 3;
                    end else dly--;
                end else if (($urandom % 16) == 0) begin
                    fv = 1; fe = $urandom % N; fl = 1;   // stray response
                    if (mv[fe]) fv = 0;
                end
                cyc(lv, a, 1'($urandom % 2), TW'($urandom), fv, fe, fl);
                if (e_req_v) begin pend = 1; pend_e = e_req_e; dly = $urandom % 4; end
            end
            for (int c = 0; c < 4000 && (model_any() || pend); c++) begin
                bit fv = 0; int fe = 0;
                if (pend) begin fv = 1; fe = pend_e; pend = 0; end
                cyc(0, '0, 0, '0, fv, fe, fv);
                if (e_req_v) begin pend = 1; pend_e = e_req_e; end
            end
        end
        cmp("R9", "drained empty", {31'd0, full}, 32'd0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        mismatched++;
        compared++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule